// File: doc/BRIEF.md
# Bundle-Aligned Branch Resolution Unit

This block looks at every branch in one instruction group and decides where fetch goes next. The group covers up to `NUM_BUNDLES` bundles of 16 bytes, and each bundle has three slots. The caller presents up to `NUM_BR` branch entries in program order, with entry 0 the earliest. Each entry carries:

- a valid bit;
- a kind;
- an indirect flag;
- its qualifying predicate value;
- a 60-bit displacement field;
- the value read from its branch register;
- its bundle index inside the group and its slot;
- the index of the branch register that receives a call's link address.

The block forms each entry's target and keeps the earliest taken entry. From that entry it produces a bundle-aligned redirect address, a mask of the group slots that must be squashed, and a link-register write request when the winner is a call. When nothing is taken, fetch continues at the supplied sequential address.

All results are registered, so they appear one clock after `in_valid`. Register-stack adjustment, decode and fetch are not part of this block.

Top module: `br_resolve`

## Requirements
- R1: Every produced address (`next_ip`, `link_addr`) has its low 4 bits equal to zero, so a redirect always lands on slot 0 of a bundle. This includes indirect targets, whose low 4 bits are cleared.
- R2: A short IP-relative branch (kind 0 cond or 1 call, indirect flag 0) targets bundle_ip + sext(disp[20:0]) * 16. Here bundle_ip = aligned `group_ip` + bundle index * 16.
- R3: Kinds 3 (long branch) and 4 (long call) are always IP-relative. They target bundle_ip + sext(disp[59:0]) * 16 and occupy their own slot and the following one.
- R4: With the indirect flag at 1 (kinds 0 and 1), the target is the branch-register value with its low 4 bits cleared.
- R5: An entry is taken only when its valid bit and its predicate are both 1. An entry with valid at 0 has no effect on any output.
- R6: When several entries are taken, the one with the lowest entry index decides every output.
- R7: The slot position of an entry is bundle index * 3 + slot. Squash mask bit p is set exactly when p is greater than the last slot position the taken branch occupies.
- R8: When the winner is a call (kind 1 or 4), `link_we` is 1 and `link_idx` is the entry's link register index. `link_addr` is bundle_ip + 16. A call that is not taken requests no write.
- R9: A return (kind 2) always resolves through the branch-register value, whatever its indirect flag and displacement hold.
- R10: With no taken entry, `redirect` is 0, `next_ip` is `seq_ip` with its low 4 bits cleared, the squash mask is 0 and `link_we` is 0.
- R11: Outputs are registered. `out_valid` is `in_valid` delayed by one clock, and reset clears `out_valid`, `redirect` and `link_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Group present this cycle |
| group_ip | input | 64 | Address of the group's first bundle |
| seq_ip | input | 64 | Sequential next address when nothing is taken |
| br_valid | input | NUM_BR | Entry valid bits |
| br_kind | input | NUM_BR*3 | Entry kinds: 0 cond, 1 call, 2 ret, 3 long, 4 long call |
| br_ind | input | NUM_BR | Indirect flag per entry |
| br_pred | input | NUM_BR | Qualifying predicate value per entry |
| br_disp | input | NUM_BR*60 | Displacement field per entry |
| br_breg | input | NUM_BR*64 | Branch-register value per entry |
| br_bidx | input | NUM_BR*BIDX_W | Bundle index within the group |
| br_slot | input | NUM_BR*2 | Slot within the bundle (0 to 2) |
| br_lidx | input | NUM_BR*3 | Link register index for calls |
| out_valid | output | 1 | Result valid |
| redirect | output | 1 | A branch was taken |
| next_ip | output | 64 | Next fetch address |
| squash | output | NUM_BUNDLES*3 | Slots to discard after the taken branch |
| link_we | output | 1 | Link-register write request |
| link_idx | output | 3 | Link register to write |
| link_addr | output | 64 | Link address |

## Verification
The hardest situation to reach is a group holding several entries that disagree: an invalid entry that looks taken, a not-taken call, and two taken branches behind them. Directed tests build such groups, so the bench sees that only the earliest valid taken entry sets the address, the mask and the link write. A long branch sitting in slot 1 is driven on its own so that the squash mask starts one slot further along. A displacement with its top bit set is used to check sign extension across the full 64-bit add.

// File: rtl/brres_pkg.sv
package brres_pkg;
    typedef enum logic [2:0] {
        BK_COND  = 3'd0,
        BK_CALL  = 3'd1,
        BK_RET   = 3'd2,
        BK_LONG  = 3'd3,
        BK_LCALL = 3'd4
    } br_kind_e;

    localparam int BUNDLE_SHIFT   = 4;
    localparam int SLOTS_PER_BNDL = 3;
    localparam int SHORT_DISP_W   = 21;
    localparam int LONG_DISP_W    = 60;
endpackage

// File: rtl/br_target.sv
module br_target
    import brres_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int BIDX_W = 2,
    parameter int POS_W  = 4
) (
    input  logic [ADDR_W-1:0]      group_ip,
    input  logic [2:0]             kind,
    input  logic                   indirect,
    input  logic [LONG_DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0]      breg_val,
    input  logic [BIDX_W-1:0]      bidx,
    input  logic [1:0]             slot,
    output logic [ADDR_W-1:0]      target,
    output logic [ADDR_W-1:0]      link_addr,
    output logic [POS_W-1:0]       last_pos,
    output logic                   is_call
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << BUNDLE_SHIFT) - 1);

    logic              is_long;
    logic              use_ind;
    logic [ADDR_W-1:0] bundle_ip;
    logic [ADDR_W-1:0] short_off;
    logic [ADDR_W-1:0] long_off;
    int                pos_i;

    always_comb begin
        is_long   = (kind == BK_LONG) || (kind == BK_LCALL);
        is_call   = (kind == BK_CALL) || (kind == BK_LCALL);
        use_ind   = (kind == BK_RET) || (indirect && !is_long);
        bundle_ip = (group_ip & ALIGN_MASK) + (ADDR_W'(bidx) << BUNDLE_SHIFT);
        short_off = ADDR_W'($signed({disp[SHORT_DISP_W-1:0], 4'b0000}));
        long_off  = ADDR_W'($signed({disp, 4'b0000}));
        if (use_ind)
            target = breg_val & ALIGN_MASK;
        else if (is_long)
            target = bundle_ip + long_off;
        else
            target = bundle_ip + short_off;
        link_addr = bundle_ip + ADDR_W'(1 << BUNDLE_SHIFT);
        pos_i     = int'(bidx) * SLOTS_PER_BNDL + int'(slot) + (is_long ? 1 : 0);
        last_pos  = POS_W'(pos_i);
    end
endmodule

// File: rtl/br_pick.sv
module br_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] taken,
    output logic [N-1:0] first,
    output logic         any
);
    always_comb begin
        first = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (taken[i] && !any) begin
                first[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
    import brres_pkg::*;
#(
    parameter int NUM_BR      = 4,
    parameter int NUM_BUNDLES = 4,
    parameter int ADDR_W      = 64,
    parameter int BREG_IDX_W  = 3,
    parameter int BIDX_W      = (NUM_BUNDLES > 1) ? $clog2(NUM_BUNDLES) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [ADDR_W-1:0]             group_ip,
    input  logic [ADDR_W-1:0]             seq_ip,
    input  logic [NUM_BR-1:0]             br_valid,
    input  logic [NUM_BR*3-1:0]           br_kind,
    input  logic [NUM_BR-1:0]             br_ind,
    input  logic [NUM_BR-1:0]             br_pred,
    input  logic [NUM_BR*LONG_DISP_W-1:0] br_disp,
    input  logic [NUM_BR*ADDR_W-1:0]      br_breg,
    input  logic [NUM_BR*BIDX_W-1:0]      br_bidx,
    input  logic [NUM_BR*2-1:0]           br_slot,
    input  logic [NUM_BR*BREG_IDX_W-1:0]  br_lidx,
    output logic                          out_valid,
    output logic                          redirect,
    output logic [ADDR_W-1:0]             next_ip,
    output logic [NUM_BUNDLES*3-1:0]      squash,
    output logic                          link_we,
    output logic [BREG_IDX_W-1:0]         link_idx,
    output logic [ADDR_W-1:0]             link_addr
);
    localparam int GROUP_SLOTS = NUM_BUNDLES * SLOTS_PER_BNDL;
    localparam int POS_W       = $clog2(GROUP_SLOTS + 1);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << BUNDLE_SHIFT) - 1);

    typedef struct packed {
        logic                   valid;
        logic                   redirect;
        logic [ADDR_W-1:0]      next_ip;
        logic [GROUP_SLOTS-1:0] squash;
        logic                   link_we;
        logic [BREG_IDX_W-1:0]  link_idx;
        logic [ADDR_W-1:0]      link_addr;
    } res_t;

    logic [ADDR_W-1:0] tgt   [NUM_BR];
    logic [ADDR_W-1:0] lnk   [NUM_BR];
    logic [POS_W-1:0]  lpos  [NUM_BR];
    logic [NUM_BR-1:0] call_v;
    logic [NUM_BR-1:0] taken;
    logic [NUM_BR-1:0] first;
    logic              any_taken;

    for (genvar i = 0; i < NUM_BR; i++) begin : g_ent
        br_target #(.ADDR_W(ADDR_W), .BIDX_W(BIDX_W), .POS_W(POS_W)) u_tgt (
            .group_ip (group_ip),
            .kind     (br_kind[i*3 +: 3]),
            .indirect (br_ind[i]),
            .disp     (br_disp[i*LONG_DISP_W +: LONG_DISP_W]),
            .breg_val (br_breg[i*ADDR_W +: ADDR_W]),
            .bidx     (br_bidx[i*BIDX_W +: BIDX_W]),
            .slot     (br_slot[i*2 +: 2]),
            .target   (tgt[i]),
            .link_addr(lnk[i]),
            .last_pos (lpos[i]),
            .is_call  (call_v[i])
        );
        assign taken[i] = br_valid[i] & br_pred[i];
    end

    br_pick #(.N(NUM_BR)) u_pick (
        .taken(taken),
        .first(first),
        .any  (any_taken)
    );

    res_t res_d, res_q;
    logic [POS_W-1:0] sel_pos;

    always_comb begin
        res_d          = '0;
        sel_pos        = '0;
        res_d.valid    = in_valid;
        res_d.redirect = in_valid && any_taken;
        res_d.next_ip  = seq_ip & ALIGN_MASK;
        for (int i = 0; i < NUM_BR; i++) begin
            if (first[i]) begin
                res_d.next_ip   = tgt[i];
                sel_pos         = lpos[i];
                res_d.link_we   = in_valid && call_v[i];
                res_d.link_idx  = br_lidx[i*BREG_IDX_W +: BREG_IDX_W];
                res_d.link_addr = lnk[i];
            end
        end
        for (int p = 0; p < GROUP_SLOTS; p++)
            res_d.squash[p] = res_d.redirect && (POS_W'(p) > sel_pos);
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign redirect  = res_q.redirect;
    assign next_ip   = res_q.next_ip;
    assign squash    = res_q.squash;
    assign link_we   = res_q.link_we;
    assign link_idx  = res_q.link_idx;
    assign link_addr = res_q.link_addr;

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    aligned_target_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (next_ip[3:0] == 4'h0));
    // R10
    no_redirect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !redirect) |-> (squash == '0 && !link_we));
    // R8
    link_needs_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (redirect && link_addr[3:0] == 4'h0));
endmodule

// File: tb/br_resolve_test.sv
module br_resolve_test;
    localparam int N  = 4;
    localparam int NB = 4;
    localparam int BW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid;
    logic [63:0] group_ip, seq_ip;
    logic [N-1:0] br_valid, br_ind, br_pred;
    logic [N*3-1:0] br_kind, br_lidx;
    logic [N*60-1:0] br_disp;
    logic [N*64-1:0] br_breg;
    logic [N*BW-1:0] br_bidx;
    logic [N*2-1:0] br_slot;
    logic out_valid, redirect, link_we;
    logic [63:0] next_ip, link_addr;
    logic [NB*3-1:0] squash;
    logic [2:0] link_idx;

    int tests = 0;
    int fails = 0;
    localparam logic [63:0] G = 64'h1000_0000_0000_1230;
    localparam logic [63:0] S = 64'h1000_0000_0000_1278;

    always #10 clk = ~clk;

    br_resolve #(.NUM_BR(N), .NUM_BUNDLES(NB)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .group_ip(group_ip), .seq_ip(seq_ip),
        .br_valid(br_valid), .br_kind(br_kind), .br_ind(br_ind), .br_pred(br_pred),
        .br_disp(br_disp), .br_breg(br_breg), .br_bidx(br_bidx), .br_slot(br_slot),
        .br_lidx(br_lidx), .out_valid(out_valid), .redirect(redirect), .next_ip(next_ip),
        .squash(squash), .link_we(link_we), .link_idx(link_idx), .link_addr(link_addr)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clear();
        in_valid = 1'b0; group_ip = G; seq_ip = S;
        br_valid = '0; br_kind = '0; br_ind = '0; br_pred = '0;
        br_disp = '0; br_breg = '0; br_bidx = '0; br_slot = '0; br_lidx = '0;
    endtask

    task automatic ent(input int i, input logic [2:0] k, input logic ind, input logic pr,
                       input logic [59:0] d, input logic [63:0] b, input logic [1:0] bi,
                       input logic [1:0] sl, input logic [2:0] li);
        br_valid[i] = 1'b1; br_kind[i*3 +: 3] = k; br_ind[i] = ind; br_pred[i] = pr;
        br_disp[i*60 +: 60] = d; br_breg[i*64 +: 64] = b; br_bidx[i*BW +: BW] = bi;
        br_slot[i*2 +: 2] = sl; br_lidx[i*3 +: 3] = li;
    endtask

    task automatic run_expect(input string req, input logic redir, input logic [63:0] nip,
                              input logic [11:0] msk, input logic lwe);
        in_valid = 1'b1;
        @(negedge clk);
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check({req, " redirect"}, {63'd0, redirect}, {63'd0, redir});
        check({req, " next_ip"}, next_ip, nip);
        check({req, " squash"}, {52'd0, squash}, {52'd0, msk});
        check({req, " link_we"}, {63'd0, link_we}, {63'd0, lwe});
        clear();
    endtask

    task automatic t_reset();
        check("R11 reset valid", {63'd0, out_valid}, 64'd0);
        check("R11 reset redirect", {63'd0, redirect}, 64'd0);
        check("R11 reset link_we", {63'd0, link_we}, 64'd0);
    endtask

    task automatic t_none();
        // R10 / R8: untaken cond and untaken call
        ent(0, 3'd0, 1'b0, 1'b0, 60'd7, 64'd0, 2'd0, 2'd1, 3'd0);
        ent(1, 3'd1, 1'b0, 1'b0, 60'd2, 64'd0, 2'd1, 2'd0, 3'd4);
        run_expect("R10 R8 none taken", 1'b0, 64'h1000_0000_0000_1270, 12'h000, 1'b0);
        @(negedge clk);
        check("R11 idle valid low", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_short();
        ent(0, 3'd0, 1'b0, 1'b1, 60'd5, 64'd0, 2'd1, 2'd0, 3'd0);
        run_expect("R2 short fwd", 1'b1, G + 64'd16 + 64'd80, 12'hFF0, 1'b0);
        ent(0, 3'd0, 1'b0, 1'b1, 60'h0F0_0000_001F_FFFE, 64'd0, 2'd0, 2'd2, 3'd0);
        run_expect("R2 short neg", 1'b1, G - 64'd32, 12'hFF8, 1'b0);
        ent(0, 3'd0, 1'b0, 1'b1, 60'h0FFFFF, 64'd0, 2'd0, 2'd0, 3'd0);
        run_expect("R2 short max", 1'b1, G + 64'hFFFFF0, 12'hFFE, 1'b0);
    endtask

    task automatic t_priority();
        // R6: entry0 not taken, entry1 and entry2 taken -> entry1 wins
        ent(0, 3'd0, 1'b0, 1'b0, 60'd3, 64'd0, 2'd0, 2'd1, 3'd0);
        ent(1, 3'd0, 1'b0, 1'b1, 60'd1, 64'd0, 2'd2, 2'd0, 3'd0);
        ent(2, 3'd1, 1'b0, 1'b1, 60'd9, 64'd0, 2'd3, 2'd0, 3'd1);
        run_expect("R6 R7 first wins", 1'b1, G + 64'd48, 12'hF80, 1'b0);
        // R5: invalid but predicate-true entry ignored
        ent(0, 3'd1, 1'b0, 1'b1, 60'd3, 64'd0, 2'd0, 2'd0, 3'd6);
        br_valid[0] = 1'b0;
        ent(1, 3'd0, 1'b0, 1'b1, 60'd0, 64'd0, 2'd1, 2'd0, 3'd0);
        run_expect("R5 invalid ignored", 1'b1, G + 64'd16, 12'hFF0, 1'b0);
    endtask

    task automatic t_indirect();
        ent(0, 3'd0, 1'b1, 1'b1, 60'd5, 64'hABCD_0000_1234_567F, 2'd0, 2'd0, 3'd0);
        run_expect("R4 R1 indirect", 1'b1, 64'hABCD_0000_1234_5670, 12'hFFE, 1'b0);
        ent(0, 3'd2, 1'b0, 1'b1, 60'd77, 64'h2000_0000_0000_0048, 2'd1, 2'd1, 3'd0);
        run_expect("R9 return", 1'b1, 64'h2000_0000_0000_0040, 12'hFE0, 1'b0);
    endtask

    task automatic t_call();
        ent(0, 3'd1, 1'b0, 1'b1, 60'd3, 64'd0, 2'd1, 2'd2, 3'd5);
        in_valid = 1'b1;
        @(negedge clk);
        check("R8 call target", next_ip, G + 64'd16 + 64'd48);
        check("R8 call link_we", {63'd0, link_we}, 64'd1);
        check("R8 call link_idx", {61'd0, link_idx}, 64'd5);
        check("R8 call link_addr", link_addr, G + 64'd32);
        check("R7 call squash", {52'd0, squash}, {52'd0, 12'hFC0});
        clear();
    endtask

    task automatic t_long();
        ent(0, 3'd3, 1'b1, 1'b1, 60'h800_0000_0000_0001, 64'hFFFF, 2'd2, 2'd1, 3'd0);
        run_expect("R3 R7 long", 1'b1, G + 64'd32 + 64'h8000_0000_0000_0010, 12'hE00, 1'b0);
        ent(0, 3'd4, 1'b0, 1'b1, 60'd1, 64'd0, 2'd3, 2'd1, 3'd2);
        in_valid = 1'b1;
        @(negedge clk);
        check("R3 lcall target", next_ip, G + 64'd64);
        check("R7 lcall squash", {52'd0, squash}, 64'd0);
        check("R8 lcall link_addr", link_addr, G + 64'd64);
        check("R8 lcall link_idx", {61'd0, link_idx}, 64'd2);
        clear();
    endtask

    initial begin
        fork
            begin
                clear();
                repeat (3) @(negedge clk);
                t_reset();
                rst = 1'b0;
                @(negedge clk);
                t_none();
                t_short();
                t_priority();
                t_indirect();
                t_call();
                t_long();
            end
            begin
                repeat (5000) @(negedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule